// File: doc/BRIEF.md
# Paged Program Sequencer with Shifting Return Stack

This block is the program-flow engine of a small 4-bit controller. It owns the program counter and a short return-address stack, and it works out the next fetch address from the control-flow operation in progress: a long jump or call through the whole program space, a jump inside the current 64-word page, a page-relative jump indexed by the accumulator, a short call into the bottom of the program, and a return, with or without a request to skip the next instruction. When no control-flow operation is active, a sequential-advance strobe steps the counter by one.

The return stack has no pointer. Every entry is a register. A push moves all entries one place deeper and puts the live PC on top, which loses the deepest entry. A pop hands the top entry to the PC, moves the rest up and fills the emptied bottom slot with zero. A plain return takes one extra machine cycle, which the block shows on a hold output. The program ROM and the instruction decode sit outside. The decoder gives the block an operation select, the low opcode bits, the second instruction byte and the accumulator.

Top module: `pc_sequencer`

## Requirements
- R1: While `rstN` is low and after it rises, `pc` is 0, `skipReq` and `holdCycle` are 0, and every stack entry holds 0, so a return taken before any call loads 0.
- R2: With `opSel` 0 (idle), or the unused code 7, the PC increments by one modulo 2^PC_W on each edge where `advance` is high, and otherwise keeps its value. `advance` has no effect while any other operation is selected.
- R3: With `opSel` 1 (long transfer), the next PC is `opLow[2:0]` concatenated above the 8-bit `operand`. When `opLow[3]` is 1 the operation is a call and the current PC is pushed first. When it is 0 the stack is untouched.
- R4: A push shifts each stack entry one place deeper and writes the current PC into the top entry. With depth 3, after four calls without a return, the first return address is gone.
- R5: A pop loads the top entry into the PC, shifts the remaining entries up by one and writes 0 into the deepest entry. Popping more times than there were pushes yields 0.
- R6: With `opSel` 2 (in-page jump), PC bits above bit 5 are kept and bits 5:0 become `opLow[5:0]`.
- R7: With `opSel` 3 (indexed jump), PC bits above bit 5 are kept and bits 5:0 become `acc` shifted left by two, with bits 1:0 zero.
- R8: With `opSel` 4 (short call), the current PC is pushed and the next PC is `opLow[3:0]` shifted left by two, zero above bit 5.
- R9: With `opSel` 6 (return and skip), the stack pops and `skipReq` is high for exactly the following cycle. `skipReq` is never high after any other operation.
- R10: With `opSel` 5 (plain return), the stack pops and `holdCycle` is high for exactly the following cycle. During that cycle `opSel` and `advance` are ignored, so the PC and the stack stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 3 | Control-flow operation select (0 idle, 1 long, 2 in-page, 3 indexed, 4 short call, 5 return, 6 return and skip) |
| opLow | input | 6 | Low six bits of the current opcode |
| operand | input | 8 | Second instruction byte |
| acc | input | 4 | Accumulator value |
| advance | input | 1 | Sequential-advance strobe |
| pc | output | PC_W | Program counter |
| skipReq | output | 1 | Request to skip the next instruction |
| holdCycle | output | 1 | Extra machine cycle of a plain return |

## Verification
The checker checks on every cycle the single-step behaviours that depend only on the ports: advance and idle holding, the in-page, indexed and short-call targets, the long-jump target, the one-cycle pulses of skip and hold, and the PC freezing during the hold cycle. What the stack holds cannot be seen at the ports. The bench scenarios show it by nesting calls past the stack depth, returning more often than it called, and confirming that the lost entry is really gone and that the refilled entries read as zero. The bench also sweeps every page offset, every accumulator value and every short-call slot against its own arithmetic model.

// File: rtl/pc_sequencer_pkg.sv
package pc_sequencer_pkg;

  localparam int PAGE_W = 6;
  localparam int ACC_W  = 4;
  localparam int LONG_W = 11;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_LONG   = 3'd1,
    OP_PAGE   = 3'd2,
    OP_INDEX  = 3'd3,
    OP_SCALL  = 3'd4,
    OP_RET    = 3'd5,
    OP_RETSK  = 3'd6,
    OP_SPARE  = 3'd7
  } seqOp_t;

  typedef struct packed {
    logic incr;
    logic push;
    logic pop;
    logic ldLong;
    logic ldPage;
    logic ldIndex;
    logic ldZero;
  } seqStrobe_t;

endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_sequencer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opSel,
  input  logic       callBit,
  input  logic       advance,
  output seqStrobe_t strobe,
  output logic       skipReq,
  output logic       holdCycle
);

  seqOp_t     opNow;
  seqStrobe_t strobeNext;
  logic       holdQ;
  logic       skipQ;

  assign opNow = seqOp_t'(opSel);

  always_comb begin
    strobeNext = '0;
    if (!holdQ) begin
      unique case (opNow)
        OP_LONG: begin
          strobeNext.ldLong = 1'b1;
          strobeNext.push   = callBit;
        end
        OP_PAGE:  strobeNext.ldPage  = 1'b1;
        OP_INDEX: strobeNext.ldIndex = 1'b1;
        OP_SCALL: begin
          strobeNext.ldZero = 1'b1;
          strobeNext.push   = 1'b1;
        end
        OP_RET, OP_RETSK: strobeNext.pop = 1'b1;
        OP_IDLE, OP_SPARE: strobeNext.incr = advance;
        default: strobeNext = '0;
      endcase
    end
  end

  assign strobe = strobeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 1'b0;
      skipQ <= 1'b0;
    end else begin
      holdQ <= !holdQ && (opNow == OP_RET);
      skipQ <= !holdQ && (opNow == OP_RETSK);
    end
  end

  assign skipReq   = skipQ;
  assign holdCycle = holdQ;

endmodule

// File: rtl/pc_seq_datapath.sv
module pc_seq_datapath
  import pc_sequencer_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [5:0]        opLow,
  input  logic [7:0]        operand,
  input  logic [ACC_W-1:0]  acc,
  output logic [PC_W-1:0]   pc
);

  localparam int HI_W = PC_W - PAGE_W;

  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] pcNext;
  logic [PC_W-1:0] stk [DEPTH];
  logic [HI_W-1:0] pageHi;
  logic [PC_W-1:0] longTarget;
  logic [PC_W-1:0] zeroTarget;

  assign pageHi     = pcQ[PC_W-1:PAGE_W];
  assign longTarget = PC_W'({opLow[2:0], operand});
  assign zeroTarget = PC_W'({opLow[3:0], 2'b00});

  always_comb begin
    pcNext = pcQ;
    if (strobe.ldLong)       pcNext = longTarget;
    else if (strobe.ldPage)  pcNext = {pageHi, opLow[PAGE_W-1:0]};
    else if (strobe.ldIndex) pcNext = {pageHi, acc, 2'b00};
    else if (strobe.ldZero)  pcNext = zeroTarget;
    else if (strobe.pop)     pcNext = stk[0];
    else if (strobe.incr)    pcNext = pcQ + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcNext;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stk
    logic [PC_W-1:0] shallower;
    logic [PC_W-1:0] deeper;
    if (i == 0) begin : g_top
      assign shallower = pcQ;
    end else begin : g_mid
      assign shallower = stk[i-1];
    end
    if (i == DEPTH - 1) begin : g_bot
      assign deeper = '0;
    end else begin : g_up
      assign deeper = stk[i+1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           stk[i] <= '0;
      else if (strobe.push) stk[i] <= shallower;
      else if (strobe.pop)  stk[i] <= deeper;
    end
  end

  assign pc = pcQ;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_sequencer_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      opSel,
  input  logic [5:0]      opLow,
  input  logic [7:0]      operand,
  input  logic [3:0]      acc,
  input  logic            advance,
  output logic [PC_W-1:0] pc,
  output logic            skipReq,
  output logic            holdCycle
);

  seqStrobe_t strobe;

  pc_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .opSel     (opSel),
    .callBit   (opLow[3]),
    .advance   (advance),
    .strobe    (strobe),
    .skipReq   (skipReq),
    .holdCycle (holdCycle)
  );

  pc_seq_datapath #(.PC_W(PC_W), .DEPTH(DEPTH)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opLow   (opLow),
    .operand (operand),
    .acc     (acc),
    .pc      (pc)
  );

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int PC_W = 11
) (
  input logic            clk,
  input logic            rstN,
  input logic [2:0]      opSel,
  input logic [5:0]      opLow,
  input logic [7:0]      operand,
  input logic [3:0]      acc,
  input logic            advance,
  input logic [PC_W-1:0] pc,
  input logic            skipReq,
  input logic            holdCycle
);

  logic isIdle;
  assign isIdle = (opSel == 3'd0) || (opSel == 3'd7);

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!holdCycle && isIdle && advance) |=> pc == $past(pc) + PC_W'(1)); // R2

  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!holdCycle && isIdle && !advance) |=> $stable(pc)); // R2

  AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (!holdCycle && opSel == 3'd1) |=> pc == PC_W'({$past(opLow[2:0]), $past(operand)})); // R3

  AST_PAGE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (!holdCycle && opSel == 3'd2) |=>
      (pc[PC_W-1:6] == $past(pc[PC_W-1:6])) && (pc[5:0] == $past(opLow))); // R6

  AST_INDEX_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (!holdCycle && opSel == 3'd3) |=>
      (pc[PC_W-1:6] == $past(pc[PC_W-1:6])) && (pc[5:0] == {$past(acc), 2'b00})); // R7

  AST_SHORT_CALL_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (!holdCycle && opSel == 3'd4) |=> pc == PC_W'({$past(opLow[3:0]), 2'b00})); // R8

  AST_SKIP_AFTER_RETSK: assert property (@(posedge clk) disable iff (!rstN)
    (!holdCycle && opSel == 3'd6) |=> skipReq); // R9

  AST_SKIP_ONLY_RETSK: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |-> $past(opSel == 3'd6) && !$past(holdCycle)); // R9

  AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    holdCycle |=> !holdCycle); // R10

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    holdCycle |=> $stable(pc) && !skipReq); // R10

endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .opSel     (opSel),
  .opLow     (opLow),
  .operand   (operand),
  .acc       (acc),
  .advance   (advance),
  .pc        (pc),
  .skipReq   (skipReq),
  .holdCycle (holdCycle)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;

  localparam int PC_W  = 11;
  localparam int DEPTH = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [2:0]      opSel = '0;
  logic [5:0]      opLow = '0;
  logic [7:0]      operand = '0;
  logic [3:0]      acc = '0;
  logic            advance = 1'b0;
  logic [PC_W-1:0] pc;
  logic            skipReq;
  logic            holdCycle;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [PC_W-1:0] mPc;
  logic [PC_W-1:0] mStk [DEPTH];
  logic            mHold;
  logic            mSkip;

  always #5 clk = ~clk;

  pc_sequencer #(.PC_W(PC_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opLow(opLow), .operand(operand),
    .acc(acc), .advance(advance), .pc(pc), .skipReq(skipReq), .holdCycle(holdCycle)
  );

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic mPush();
    for (int i = DEPTH - 1; i > 0; i--) mStk[i] = mStk[i-1];
    mStk[0] = mPc;
  endtask

  task automatic mPop();
    mPc = mStk[0];
    for (int i = 0; i < DEPTH - 1; i++) mStk[i] = mStk[i+1];
    mStk[DEPTH-1] = '0;
  endtask

  // apply one operation for one edge, update the model, check outputs
  task automatic doOp(input string req, input logic [2:0] op, input logic [5:0] lo,
                      input logic [7:0] arg, input logic [3:0] a, input logic adv);
    logic wasHold;
    opSel = op; opLow = lo; operand = arg; acc = a; advance = adv;
    wasHold = mHold;
    mHold = 1'b0;
    mSkip = 1'b0;
    if (!wasHold) begin
      case (op)
        3'd1: begin
          if (lo[3]) mPush();
          mPc = {lo[2:0], arg};
        end
        3'd2: mPc = {mPc[PC_W-1:6], lo};
        3'd3: mPc = {mPc[PC_W-1:6], a, 2'b00};
        3'd4: begin
          mPush();
          mPc = PC_W'({lo[3:0], 2'b00});
        end
        3'd5: begin mPop(); mHold = 1'b1; end
        3'd6: begin mPop(); mSkip = 1'b1; end
        default: if (adv) mPc = mPc + PC_W'(1);
      endcase
    end
    @(posedge clk);
    #2;
    check(req, int'(pc), int'(mPc));
    check(req, int'(skipReq), int'(mSkip));
    check(req, int'(holdCycle), int'(mHold));
    opSel = '0; advance = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    mPc = '0; mHold = 1'b0; mSkip = 1'b0;
    for (int i = 0; i < DEPTH; i++) mStk[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: values during reset
    check("R1", int'(pc), 0);
    check("R1", int'(skipReq), 0);
    check("R1", int'(holdCycle), 0);
    rstN = 1'b1;
    @(posedge clk); #2;
    check("R1", int'(pc), 0);

    // R2: idle holds, advance steps
    doOp("R2", 3'd0, 6'h15, 8'hAA, 4'h3, 1'b0);
    for (int k = 0; k < 20; k++) doOp("R2", 3'd0, 6'(k), 8'(k), 4'(k), 1'b1);
    doOp("R2", 3'd7, 6'h3F, 8'hFF, 4'hF, 1'b1);
    doOp("R2", 3'd7, 6'h3F, 8'hFF, 4'hF, 1'b0);

    // R3: long jump sweep, no push
    for (int hi = 0; hi < 8; hi++) begin
      doOp("R3", 3'd1, 6'(hi), 8'h00, 4'h0, 1'b1);
      doOp("R3", 3'd1, 6'(hi) | 6'h30, 8'h5A, 4'h0, 1'b0);
      doOp("R3", 3'd1, 6'(hi), 8'hFF, 4'h0, 1'b1);
    end
    // R2: wrap at top of program
    doOp("R2", 3'd1, 6'h07, 8'hFF, 4'h0, 1'b0);
    doOp("R2", 3'd0, 6'h00, 8'h00, 4'h0, 1'b1);

    // R6: every in-page offset
    doOp("R6", 3'd1, 6'h05, 8'hC3, 4'h0, 1'b0);
    for (int o = 0; o < 64; o++) doOp("R6", 3'd2, 6'(o), 8'(o * 3), 4'(o), 1'b1);

    // R7: every accumulator value
    doOp("R7", 3'd1, 6'h02, 8'h47, 4'h0, 1'b0);
    for (int a = 0; a < 16; a++) doOp("R7", 3'd3, 6'(a * 5), 8'h11, 4'(a), 1'b1);

    // R4/R5: nest four calls in a depth-3 stack, then return five times
    doOp("R4", 3'd1, 6'h0B, 8'h10, 4'h0, 1'b0);
    doOp("R4", 3'd0, 6'h00, 8'h00, 4'h0, 1'b1);
    doOp("R4", 3'd1, 6'h0C, 8'h20, 4'h0, 1'b0);
    doOp("R4", 3'd0, 6'h00, 8'h00, 4'h0, 1'b1);
    doOp("R4", 3'd1, 6'h0D, 8'h30, 4'h0, 1'b0);
    doOp("R4", 3'd4, 6'h09, 8'h00, 4'h0, 1'b0);
    doOp("R5", 3'd6, 6'h00, 8'h00, 4'h0, 1'b0);
    doOp("R5", 3'd6, 6'h00, 8'h00, 4'h0, 1'b0);
    doOp("R5", 3'd5, 6'h00, 8'h00, 4'h0, 1'b0);
    // R10: the held cycle ignores a jump and advance
    doOp("R10", 3'd2, 6'h2A, 8'h00, 4'h0, 1'b1);
    doOp("R5", 3'd6, 6'h00, 8'h00, 4'h0, 1'b0);
    check("R5", int'(pc), 0);
    doOp("R5", 3'd5, 6'h00, 8'h00, 4'h0, 1'b1);
    doOp("R10", 3'd4, 6'h0F, 8'h00, 4'h0, 1'b1);
    check("R10", int'(pc), 0);

    // R8/R9: every short-call slot followed by return-and-skip
    doOp("R8", 3'd1, 6'h06, 8'h9C, 4'h0, 1'b0);
    for (int s = 0; s < 16; s++) begin
      doOp("R8", 3'd4, 6'(s) | 6'h30, 8'hFF, 4'h0, 1'b1);
      doOp("R9", 3'd0, 6'h00, 8'h00, 4'h0, 1'b1);
      doOp("R9", 3'd6, 6'h00, 8'h00, 4'h0, 1'b1);
      doOp("R9", 3'd0, 6'h00, 8'h00, 4'h0, 1'b1);
    end

    // R10: back-to-back plain returns; the second falls in the hold cycle
    doOp("R10", 3'd1, 6'h0A, 8'h77, 4'h0, 1'b0);
    doOp("R10", 3'd5, 6'h00, 8'h00, 4'h0, 1'b0);
    doOp("R10", 3'd5, 6'h00, 8'h00, 4'h0, 1'b0);
    doOp("R10", 3'd0, 6'h00, 8'h00, 4'h0, 1'b1);

    // R1: reset mid-run clears PC and the stack
    doOp("R1", 3'd1, 6'h0F, 8'h3C, 4'h0, 1'b0);
    rstN = 1'b0;
    #3;
    check("R1", int'(pc), 0);
    @(posedge clk); #2;
    rstN = 1'b1;
    mPc = '0; mHold = 1'b0;
    for (int i = 0; i < DEPTH; i++) mStk[i] = '0;
    doOp("R1", 3'd6, 6'h00, 8'h00, 4'h0, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule